// File: doc/BRIEF.md
# ECC Read-Modify-Write Write-Path Controller

This block sits between a host request port and the command and data queues of a memory controller. Every stored word carries a check field that corrects any single flipped bit and detects any two flipped bits. Each accepted request runs on its own from start to finish. A host read fetches the word, corrects it and returns it. A full-word write is encoded and sent to memory at once. A write that covers only some bytes of the word starts a sequence instead: fetch the stored word, correct it, overlay the new bytes, encode the result and write the whole word back. That sequence takes more cycles, and the host sees the extra time as a longer period with ready held low.

A build-time option selects a plain variant for the narrow-bus mode. In that variant no check bits are made or tested, byte enables go straight to memory, and no fetch happens before a write. The memory side is one command port (read or write, with valid/ready) plus a read-return strobe. Only one request is in flight at a time, and every request ends with a one-cycle response pulse.

Top module: `ecc_rmw_ctrl`

## Requirements
- R1: A write with all byte enables set takes no memory read. The controller sends exactly one memory write with the host data, and the response follows two cycles after acceptance when the memory port is ready.
- R2: Check field layout. Data bits fill the codeword positions 1..38 that are not powers of two, in ascending order (data bit 0 at position 3). Check bit i (i = 0..5) is the even parity of all positions whose index has bit i set. Check bit 6 is the even parity of all 32 data bits together with check bits 0..5.
- R3: A write whose byte enables are neither all set nor all clear first reads the stored word, then writes back one full word (all memory byte enables set). Byte k (bits 8k+7..8k) is taken from the host where enable bit k is set and from the corrected stored word elsewhere. The check bits are those of the merged word.
- R4: A single flipped bit in the stored data or check field is corrected before the data is returned or merged. `corr_pulse` is high for exactly one cycle for that request.
- R5: A double-bit error found by the fetch sets `rsp_err`. For a partial write the write-back is dropped and the memory is left unchanged.
- R6: A host read returns the corrected stored word on `rsp_rdata` in the cycle that `rsp_valid` is high, with `rsp_err` low when no double error exists.
- R7: `req_ready` is low from the cycle after acceptance until the response cycle. `rsp_valid` lasts one cycle. A partial write takes at least three more cycles than a full write.
- R8: A write with all byte enables clear responds in the cycle after acceptance and issues no memory command.
- R9: With `ECC_ON` = 0, writes pass the host byte enables to memory with a zero check field and no prior read. Reads return raw stored data, and `corr_pulse` stays low.
- R10: While reset is asserted, `req_ready` is high and `mem_cmd_valid` and `rsp_valid` are low.
- R11: While `mem_cmd_valid` is high and `mem_cmd_ready` is low, the command, address and write data hold steady into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte enables of the write |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | DATA_W | Read data (corrected) |
| rsp_err | output | 1 | Uncorrectable error seen |
| corr_pulse | output | 1 | Single-bit error was corrected |
| mem_cmd_valid | output | 1 | Memory command valid |
| mem_cmd_ready | input | 1 | Memory accepts the command |
| mem_cmd_write | output | 1 | 1 = write command |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Data to store |
| mem_wcheck | output | 7 | Check bits to store (width derived from DATA_W) |
| mem_wbe | output | DATA_W/8 | Byte enables to memory |
| mem_rvalid | input | 1 | Read return strobe |
| mem_rdata | input | DATA_W | Stored data returned |
| mem_rcheck | input | 7 | Stored check bits returned |

## Verification
Full writes use all-zero, all-one, single-bit and random data, which separates a wrong parity coverage set from a wrong overall-parity bit. Partial writes use several enable masks over known stored words, so a swapped byte lane or a merge that takes the wrong side shows up in the stored word. Errors are injected into data bits, Hamming check bits and the overall parity bit, which separates correction of data from correction of the check field. Double errors show whether the write-back is really dropped. A random phase with a stalling memory port and varying read latency, checked against a bench model, exercises held commands and the latency difference between full and partial writes. A second build with the code disabled confirms raw pass-through.

// File: rtl/ecc_rmw_pkg.sv
package ecc_rmw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_REQ,
      ST_RD_WAIT,
      ST_MERGE,
      ST_WR_REQ,
      ST_RESP
   } rmw_state_e;

   // Number of Hamming parity bits needed for dw data bits.
   function automatic int hamming_bits(input int dw);
      int p;
      p = 1;
      for (int k = 0; k < 20; k++) begin
         if ((1 << p) < dw + p + 1) p++;
      end
      return p;
   endfunction

   // Codeword position (1-based) of data bit j: the j-th non power of two.
   function automatic int data_pos(input int j);
      int cnt;
      int res;
      cnt = 0;
      res = 0;
      for (int q = 1; q < j + 40; q++) begin
         if ((q & (q - 1)) != 0) begin
            if (cnt == j && res == 0) res = q;
            cnt++;
         end
      end
      return res;
   endfunction

endpackage

// File: rtl/ecc_rmw_enc.sv
module ecc_rmw_enc
   import ecc_rmw_pkg::*;
#(
   parameter  int DATA_W = 32,
   localparam int PAR_W  = hamming_bits(DATA_W),
   localparam int CHK_W  = PAR_W + 1
) (
   input  logic [DATA_W-1:0] data,
   output logic [CHK_W-1:0]  check
);

   function automatic logic [DATA_W-1:0] cover_mask(input int i);
      logic [DATA_W-1:0] m;
      for (int j = 0; j < DATA_W; j++) begin
         m[j] = ((data_pos(j) >> i) & 1) == 1;
      end
      return m;
   endfunction

   logic [PAR_W-1:0] par;

   for (genvar i = 0; i < PAR_W; i++) begin : g_par
      localparam logic [DATA_W-1:0] MASK = cover_mask(i);
      assign par[i] = ^(data & MASK);
   end

   assign check = {(^data) ^ (^par), par};

endmodule

// File: rtl/ecc_rmw_dec.sv
module ecc_rmw_dec
   import ecc_rmw_pkg::*;
#(
   parameter  int DATA_W = 32,
   localparam int PAR_W  = hamming_bits(DATA_W),
   localparam int CHK_W  = PAR_W + 1
) (
   input  logic [DATA_W-1:0] rdata,
   input  logic [CHK_W-1:0]  rcheck,
   output logic [DATA_W-1:0] cdata,
   output logic              single_err,
   output logic              double_err
);

   localparam logic [PAR_W-1:0] LAST_POS = PAR_W'(DATA_W + PAR_W);

   logic [CHK_W-1:0] fresh;
   logic [PAR_W-1:0] syn;
   logic             ov;

   ecc_rmw_enc #(.DATA_W(DATA_W)) u_enc (
      .data  (rdata),
      .check (fresh)
   );

   assign syn = fresh[PAR_W-1:0] ^ rcheck[PAR_W-1:0];
   // overall parity over the received codeword
   assign ov  = fresh[PAR_W] ^ rcheck[PAR_W] ^ (^syn);

   assign single_err = ov && (syn <= LAST_POS);
   assign double_err = (!ov && (syn != '0)) || (ov && (syn > LAST_POS));

   for (genvar j = 0; j < DATA_W; j++) begin : g_fix
      localparam int POS = data_pos(j);
      assign cdata[j] = rdata[j] ^ (ov && (syn == POS[PAR_W-1:0]));
   end

endmodule

// File: rtl/ecc_rmw_merge.sv
module ecc_rmw_merge #(
   parameter  int DATA_W = 32,
   localparam int BE_W   = DATA_W / 8
) (
   input  logic [DATA_W-1:0] old_word,
   input  logic [DATA_W-1:0] new_word,
   input  logic [BE_W-1:0]   be,
   output logic [DATA_W-1:0] merged
);

   for (genvar k = 0; k < BE_W; k++) begin : g_lane
      assign merged[8*k +: 8] = be[k] ? new_word[8*k +: 8] : old_word[8*k +: 8];
   end

endmodule

// File: rtl/ecc_rmw_ctrl.sv
module ecc_rmw_ctrl
   import ecc_rmw_pkg::*;
#(
   parameter  int DATA_W = 32,
   parameter  int ADDR_W = 10,
   parameter  bit ECC_ON = 1'b1,
   localparam int BE_W   = DATA_W / 8,
   localparam int CHK_W  = hamming_bits(DATA_W) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [BE_W-1:0]   req_be,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_err,
   output logic              corr_pulse,
   output logic              mem_cmd_valid,
   input  logic              mem_cmd_ready,
   output logic              mem_cmd_write,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [CHK_W-1:0]  mem_wcheck,
   output logic [BE_W-1:0]   mem_wbe,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [CHK_W-1:0]  mem_rcheck
);

   localparam logic [BE_W-1:0] BE_ALL = '1;

   if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_width
      $error("ecc_rmw_ctrl: DATA_W must be a positive multiple of 8");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ecc_rmw_ctrl: ADDR_W must be at least 1");
   end

   rmw_state_e        state_q, state_d;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] word_q;
   logic [BE_W-1:0]   be_q;
   logic              wr_q;
   logic              err_q;
   logic              ce_q;

   logic [DATA_W-1:0] fix_data;
   logic [DATA_W-1:0] merged;
   logic [CHK_W-1:0]  enc_chk;
   logic              sgl_err;
   logic              dbl_err;
   logic              accept;
   logic              partial_in;

   assign accept     = req_valid && req_ready;
   assign partial_in = (req_be != BE_ALL) && (req_be != '0);

   if (ECC_ON) begin : g_ecc
      ecc_rmw_enc #(.DATA_W(DATA_W)) u_enc (
         .data  (word_q),
         .check (enc_chk)
      );
      ecc_rmw_dec #(.DATA_W(DATA_W)) u_dec (
         .rdata      (mem_rdata),
         .rcheck     (mem_rcheck),
         .cdata      (fix_data),
         .single_err (sgl_err),
         .double_err (dbl_err)
      );
      assign mem_wbe = BE_ALL;
   end else begin : g_raw
      assign enc_chk  = '0;
      assign fix_data = mem_rdata;
      assign sgl_err  = 1'b0;
      assign dbl_err  = 1'b0;
      assign mem_wbe  = be_q;
   end

   ecc_rmw_merge #(.DATA_W(DATA_W)) u_merge (
      .old_word (word_q),
      .new_word (wdata_q),
      .be       (be_q),
      .merged   (merged)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (req_valid) begin
               if (!req_write)                  state_d = ST_RD_REQ;
               else if (req_be == '0)           state_d = ST_RESP;
               else if (!ECC_ON || !partial_in) state_d = ST_WR_REQ;
               else                             state_d = ST_RD_REQ;
            end
         end
         ST_RD_REQ:  if (mem_cmd_ready) state_d = ST_RD_WAIT;
         ST_RD_WAIT: begin
            if (mem_rvalid) begin
               if (!wr_q || dbl_err) state_d = ST_RESP;
               else                  state_d = ST_MERGE;
            end
         end
         ST_MERGE:   state_d = ST_WR_REQ;
         ST_WR_REQ:  if (mem_cmd_ready) state_d = ST_RESP;
         ST_RESP:    state_d = ST_IDLE;
         default:    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         wdata_q <= '0;
         word_q  <= '0;
         be_q    <= '0;
         wr_q    <= 1'b0;
         err_q   <= 1'b0;
         ce_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         ce_q    <= (state_q == ST_RD_WAIT) && mem_rvalid && sgl_err;
         if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            word_q  <= req_wdata;
            be_q    <= req_be;
            wr_q    <= req_write;
            err_q   <= 1'b0;
         end else if (state_q == ST_RD_WAIT && mem_rvalid) begin
            word_q <= fix_data;
            err_q  <= dbl_err;
         end else if (state_q == ST_MERGE) begin
            word_q <= merged;
         end
      end
   end

   assign req_ready     = (state_q == ST_IDLE);
   assign mem_cmd_valid = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
   assign mem_cmd_write = (state_q == ST_WR_REQ);
   assign mem_addr      = addr_q;
   assign mem_wdata     = word_q;
   assign mem_wcheck    = enc_chk;
   assign rsp_valid     = (state_q == ST_RESP);
   assign rsp_rdata     = word_q;
   assign rsp_err       = err_q;
   assign corr_pulse    = ce_q;

endmodule

// File: rtl/ecc_rmw_ctrl_chk.sv
module ecc_rmw_ctrl_chk #(
   parameter  int DATA_W = 32,
   parameter  int ADDR_W = 10,
   parameter  bit ECC_ON = 1'b1,
   localparam int BE_W   = DATA_W / 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_write,
   input logic [BE_W-1:0]   req_be,
   input logic              rsp_valid,
   input logic              corr_pulse,
   input logic              mem_cmd_valid,
   input logic              mem_cmd_ready,
   input logic              mem_cmd_write,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic [BE_W-1:0]   mem_wbe
);

   // R10: quiet outputs while held in reset
   assert_reset_quiet_R10: assert property (@(posedge clk)
      !rst_n |-> (req_ready && !mem_cmd_valid && !rsp_valid));

   // R7: busy after acceptance
   assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R7: single-cycle response
   assert_rsp_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R8: empty write answers next cycle without memory traffic
   assert_empty_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_write && req_be == '0) |=> (rsp_valid && !mem_cmd_valid));

   // R11: command holds while memory stalls
   assert_cmd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_cmd_valid && !mem_cmd_ready) |=>
         (mem_cmd_valid && $stable(mem_cmd_write) && $stable(mem_addr) && $stable(mem_wdata)));

   if (ECC_ON) begin : g_on
      // R4: correction flag is a pulse
      assert_corr_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
         corr_pulse |=> !corr_pulse);
      // R3: every write to memory is a full word
      assert_full_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (mem_cmd_valid && mem_cmd_write) |-> (mem_wbe == '1));
   end else begin : g_off
      // R9: no correction activity in the plain variant
      assert_no_corr_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid || mem_cmd_valid || rsp_valid) |-> !corr_pulse);
   end

endmodule

bind ecc_rmw_ctrl ecc_rmw_ctrl_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W),
   .ECC_ON (ECC_ON)
) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .req_write     (req_write),
   .req_be        (req_be),
   .rsp_valid     (rsp_valid),
   .corr_pulse    (corr_pulse),
   .mem_cmd_valid (mem_cmd_valid),
   .mem_cmd_ready (mem_cmd_ready),
   .mem_cmd_write (mem_cmd_write),
   .mem_addr      (mem_addr),
   .mem_wdata     (mem_wdata),
   .mem_wbe       (mem_wbe)
);

// File: tb/ecc_rmw_ctrl_tb_top.sv
module ecc_rmw_ctrl_tb_mem #(
   parameter int AW = 4,
   parameter int DW = 32,
   parameter int CW = 7
) (
   input  logic          clk,
   input  logic          stall_en,
   input  logic          cmd_valid,
   output logic          cmd_ready,
   input  logic          cmd_write,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic [CW-1:0] wcheck,
   input  logic [DW/8-1:0] wbe,
   output logic          rvalid,
   output logic [DW-1:0] rdata,
   output logic [CW-1:0] rcheck,
   input  logic          inj_en,
   input  logic [AW-1:0] inj_addr,
   input  logic [DW-1:0] inj_dmask,
   input  logic [CW-1:0] inj_cmask,
   output int            rd_cnt,
   output int            wr_cnt
);
   logic [DW-1:0] dat [1<<AW];
   logic [CW-1:0] chk [1<<AW];
   logic          pend;
   int            lat;
   logic [AW-1:0] raddr;

   initial begin
      for (int i = 0; i < (1 << AW); i++) begin
         dat[i] = '0;
         chk[i] = '0;
      end
      pend = 0; lat = 0; raddr = '0; rvalid = 0; rdata = '0; rcheck = '0;
      rd_cnt = 0; wr_cnt = 0; cmd_ready = 1;
   end

   always @(negedge clk) cmd_ready <= stall_en ? (($urandom % 3) != 0) : 1'b1;

   always @(posedge clk) begin
      rvalid <= 1'b0;
      if (pend) begin
         if (lat <= 1) begin
            rvalid <= 1'b1;
            rdata  <= dat[raddr];
            rcheck <= chk[raddr];
            pend   <= 1'b0;
         end else begin
            lat <= lat - 1;
         end
      end
      if (cmd_valid && cmd_ready) begin
         if (cmd_write) begin
            for (int k = 0; k < DW / 8; k++)
               if (wbe[k]) dat[addr][8*k +: 8] <= wdata[8*k +: 8];
            chk[addr] <= wcheck;
            wr_cnt <= wr_cnt + 1;
         end else begin
            pend   <= 1'b1;
            raddr  <= addr;
            lat    <= stall_en ? 1 + int'($urandom % 3) : 1;
            rd_cnt <= rd_cnt + 1;
         end
      end
      if (inj_en) begin
         dat[inj_addr] <= dat[inj_addr] ^ inj_dmask;
         chk[inj_addr] <= chk[inj_addr] ^ inj_cmask;
      end
   end
endmodule

module ecc_rmw_ctrl_tb_top;
   localparam int AW = 4;
   localparam int DW = 32;
   localparam int CW = 7;

   logic clk = 0;
   logic rst_n = 0;
   always #4 clk = ~clk;   // 8 ns period, 125 MHz

   int total = 0;
   int bad = 0;

   logic          req_valid0 = 0, req_valid1 = 0;
   logic          req_write = 0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [3:0]    req_be = '0;
   logic          stall_en = 0;
   logic          inj_en0 = 0, inj_en1 = 0;
   logic [AW-1:0] inj_addr = '0;
   logic [DW-1:0] inj_dmask = '0;
   logic [CW-1:0] inj_cmask = '0;

   logic rdy0, rspv0, err0, ce0, rdy1, rspv1, err1, ce1;
   logic [DW-1:0] rdat0, rdat1;
   logic mv0, mr0, mw0, rv0, mv1, mr1, mw1, rv1;
   logic [AW-1:0] ma0, ma1;
   logic [DW-1:0] mwd0, mrd0, mwd1, mrd1;
   logic [CW-1:0] mwc0, mrc0, mwc1, mrc1;
   logic [3:0] mbe0, mbe1;
   int rdc0, wrc0, rdc1, wrc1;

   ecc_rmw_ctrl #(.DATA_W(DW), .ADDR_W(AW), .ECC_ON(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid0), .req_ready(rdy0),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .rsp_valid(rspv0), .rsp_rdata(rdat0), .rsp_err(err0), .corr_pulse(ce0),
      .mem_cmd_valid(mv0), .mem_cmd_ready(mr0), .mem_cmd_write(mw0), .mem_addr(ma0),
      .mem_wdata(mwd0), .mem_wcheck(mwc0), .mem_wbe(mbe0),
      .mem_rvalid(rv0), .mem_rdata(mrd0), .mem_rcheck(mrc0));

   ecc_rmw_ctrl_tb_mem #(.AW(AW), .DW(DW), .CW(CW)) mem0_i (
      .clk(clk), .stall_en(stall_en), .cmd_valid(mv0), .cmd_ready(mr0), .cmd_write(mw0),
      .addr(ma0), .wdata(mwd0), .wcheck(mwc0), .wbe(mbe0), .rvalid(rv0), .rdata(mrd0),
      .rcheck(mrc0), .inj_en(inj_en0), .inj_addr(inj_addr), .inj_dmask(inj_dmask),
      .inj_cmask(inj_cmask), .rd_cnt(rdc0), .wr_cnt(wrc0));

   ecc_rmw_ctrl #(.DATA_W(DW), .ADDR_W(AW), .ECC_ON(1'b0)) dut_nb_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid1), .req_ready(rdy1),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .rsp_valid(rspv1), .rsp_rdata(rdat1), .rsp_err(err1), .corr_pulse(ce1),
      .mem_cmd_valid(mv1), .mem_cmd_ready(mr1), .mem_cmd_write(mw1), .mem_addr(ma1),
      .mem_wdata(mwd1), .mem_wcheck(mwc1), .mem_wbe(mbe1),
      .mem_rvalid(rv1), .mem_rdata(mrd1), .mem_rcheck(mrc1));

   ecc_rmw_ctrl_tb_mem #(.AW(AW), .DW(DW), .CW(CW)) mem1_i (
      .clk(clk), .stall_en(stall_en), .cmd_valid(mv1), .cmd_ready(mr1), .cmd_write(mw1),
      .addr(ma1), .wdata(mwd1), .wcheck(mwc1), .wbe(mbe1), .rvalid(rv1), .rdata(mrd1),
      .rcheck(mrc1), .inj_en(inj_en1), .inj_addr(inj_addr), .inj_dmask(inj_dmask),
      .inj_cmask(inj_cmask), .rd_cnt(rdc1), .wr_cnt(wrc1));

   // Reference code: build the 38-position codeword, then take parities.
   function automatic logic [CW-1:0] ref_code(input logic [DW-1:0] d);
      logic [63:0] cw;
      logic [CW-1:0] c;
      int j;
      cw = '0;
      j = 0;
      for (int q = 1; q <= 38; q++) begin
         if ((q & (q - 1)) != 0) begin
            cw[q] = d[j];
            j++;
         end
      end
      for (int i = 0; i < 6; i++) begin
         c[i] = 1'b0;
         for (int q = 1; q <= 38; q++)
            if (((q >> i) & 1) == 1) c[i] = c[i] ^ cw[q];
      end
      c[6] = (^d) ^ (^c[5:0]);
      return c;
   endfunction

   function automatic logic [DW-1:0] ref_merge(input logic [DW-1:0] o, input logic [DW-1:0] n,
                                              input logic [3:0] be);
      logic [DW-1:0] r;
      r = o;
      for (int k = 0; k < 4; k++) if (be[k]) r[8*k +: 8] = n[8*k +: 8];
      return r;
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_op(input int sel, input bit wr, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic [3:0] be,
                        output logic [DW-1:0] rd, output bit er, output int cyc,
                        output int cec, output bit busy_bad);
      bit ok;
      @(negedge clk);
      req_write = wr; req_addr = a; req_wdata = d; req_be = be;
      if (sel == 0) req_valid0 = 1; else req_valid1 = 1;
      forever begin
         ok = (sel == 0) ? rdy0 : rdy1;
         @(posedge clk);
         if (ok) break;
         @(negedge clk);
      end
      @(negedge clk);
      req_valid0 = 0; req_valid1 = 0;
      cyc = 1; cec = 0; busy_bad = 0; rd = '0; er = 0;
      forever begin
         if (((sel == 0) ? ce0 : ce1) === 1'b1) cec++;
         if (((sel == 0) ? rspv0 : rspv1) === 1'b1) begin
            rd = (sel == 0) ? rdat0 : rdat1;
            er = (sel == 0) ? err0 : err1;
            break;
         end
         if (((sel == 0) ? rdy0 : rdy1) !== 1'b0) busy_bad = 1;
         if (cyc > 300) break;
         @(negedge clk);
         cyc++;
      end
      @(negedge clk);
      if (((sel == 0) ? ce0 : ce1) === 1'b1) cec++;
   endtask

   task automatic inject(input int sel, input logic [AW-1:0] a, input logic [DW-1:0] dm,
                         input logic [CW-1:0] cm);
      @(negedge clk);
      inj_addr = a; inj_dmask = dm; inj_cmask = cm;
      if (sel == 0) inj_en0 = 1; else inj_en1 = 1;
      @(negedge clk);
      inj_en0 = 0; inj_en1 = 0;
   endtask

   logic [DW-1:0] shadow [16];
   bit            dirty  [16];

   initial begin
      logic [DW-1:0] rd, dv, nd, dpre;
      logic [CW-1:0] cpre;
      bit er, bb;
      int cyc, cec, cyc_full, rc, wc;
      int seed;

      seed = int'($urandom(32'd20240607));
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R10 ready in reset", {63'd0, rdy0}, 64'd1);
      check("R10 no mem cmd in reset", {63'd0, mv0}, 64'd0);
      check("R10 no rsp in reset", {63'd0, rspv0}, 64'd0);
      rst_n = 1;

      // R1/R2: full writes with distinct data patterns
      for (int i = 0; i < 16; i++) begin
         dv = (i == 0) ? 32'h0 : (i == 1) ? 32'hFFFF_FFFF : (i == 2) ? 32'h0000_0001 :
              (i == 3) ? 32'hA5A5_1234 : (i == 4) ? 32'h8000_0000 : $urandom;
         rc = rdc0; wc = wrc0;
         do_op(0, 1, AW'(i), dv, 4'hF, rd, er, cyc, cec, bb);
         check("R1 full write data", {32'd0, mem0_i.dat[i]}, {32'd0, dv});
         check("R2 full write check bits", {57'd0, mem0_i.chk[i]}, {57'd0, ref_code(dv)});
         check("R1 no read on full write", 64'(rdc0 - rc), 64'd0);
         check("R1 single write", 64'(wrc0 - wc), 64'd1);
         check("R7 busy during full write", {63'd0, bb}, 64'd0);
         if (i == 3) begin
            check("R1 full write latency", 64'(cyc), 64'd2);
            cyc_full = cyc;
         end
         shadow[i] = dv; dirty[i] = 0;
      end

      // R3: partial write merges bytes 0 and 2
      rc = rdc0;
      do_op(0, 1, 4'd3, 32'h1122_3344, 4'b0101, rd, er, cyc, cec, bb);
      nd = ref_merge(32'hA5A5_1234, 32'h1122_3344, 4'b0101);
      check("R3 merged data", {32'd0, mem0_i.dat[3]}, {32'd0, nd});
      check("R3 merged check bits", {57'd0, mem0_i.chk[3]}, {57'd0, ref_code(nd)});
      check("R3 fetch before write", 64'(rdc0 - rc), 64'd1);
      check("R7 partial slower than full", {63'd0, cyc >= cyc_full + 3}, 64'd1);
      check("R7 busy during partial", {63'd0, bb}, 64'd0);
      shadow[3] = nd;

      // R6: plain read
      do_op(0, 0, 4'd3, 32'h0, 4'h0, rd, er, cyc, cec, bb);
      check("R6 read data", {32'd0, rd}, {32'd0, nd});
      check("R6 read no error", {63'd0, er}, 64'd0);
      check("R4 no pulse on clean read", 64'(cec), 64'd0);

      // R4: data bit error corrected on read, then on merge
      inject(0, 4'd3, 32'h0002_0000, 7'h0);
      do_op(0, 0, 4'd3, 32'h0, 4'h0, rd, er, cyc, cec, bb);
      check("R4 corrected read data", {32'd0, rd}, {32'd0, nd});
      check("R4 one pulse on read", 64'(cec), 64'd1);
      do_op(0, 1, 4'd3, 32'hDE00_0000, 4'b1000, rd, er, cyc, cec, bb);
      nd = ref_merge(nd, 32'hDE00_0000, 4'b1000);
      check("R4 merge uses corrected word", {32'd0, mem0_i.dat[3]}, {32'd0, nd});
      check("R4 merge check bits", {57'd0, mem0_i.chk[3]}, {57'd0, ref_code(nd)});
      check("R4 one pulse on merge", 64'(cec), 64'd1);
      shadow[3] = nd;

      // R4: errors in Hamming check bit and overall parity bit
      inject(0, 4'd5, 32'h0, 7'h04);
      do_op(0, 0, 4'd5, 32'h0, 4'h0, rd, er, cyc, cec, bb);
      check("R4 check-bit error data", {32'd0, rd}, {32'd0, shadow[5]});
      check("R4 check-bit error pulse", 64'(cec), 64'd1);
      inject(0, 4'd6, 32'h0, 7'h40);
      do_op(0, 0, 4'd6, 32'h0, 4'h0, rd, er, cyc, cec, bb);
      check("R4 overall-bit error data", {32'd0, rd}, {32'd0, shadow[6]});
      check("R4 overall-bit error pulse", 64'(cec), 64'd1);
      check("R4 overall-bit error no err", {63'd0, er}, 64'd0);

      // R5: double error
      inject(0, 4'd7, 32'h0000_0081, 7'h0);
      do_op(0, 0, 4'd7, 32'h0, 4'h0, rd, er, cyc, cec, bb);
      check("R5 double error on read", {63'd0, er}, 64'd1);
      dpre = mem0_i.dat[7]; cpre = mem0_i.chk[7]; wc = wrc0;
      do_op(0, 1, 4'd7, 32'hFFFF_FFFF, 4'b0010, rd, er, cyc, cec, bb);
      check("R5 double error on partial", {63'd0, er}, 64'd1);
      check("R5 data unchanged", {32'd0, mem0_i.dat[7]}, {32'd0, dpre});
      check("R5 check unchanged", {57'd0, mem0_i.chk[7]}, {57'd0, cpre});
      check("R5 no write-back", 64'(wrc0 - wc), 64'd0);

      // R8: empty write
      rc = rdc0; wc = wrc0;
      do_op(0, 1, 4'd8, 32'h1234_5678, 4'h0, rd, er, cyc, cec, bb);
      check("R8 empty write latency", 64'(cyc), 64'd1);
      check("R8 no memory access", 64'(rdc0 - rc + wrc0 - wc), 64'd0);
      check("R8 memory untouched", {32'd0, mem0_i.dat[8]}, {32'd0, shadow[8]});

      // clean up words left corrupted by directed tests
      for (int i = 5; i <= 7; i++) begin
         do_op(0, 1, AW'(i), 32'h0F0F_0000 + i, 4'hF, rd, er, cyc, cec, bb);
         shadow[i] = 32'h0F0F_0000 + i; dirty[i] = 0;
      end

      // R11 and random mix with stalling memory
      stall_en = 1;
      for (int n = 0; n < 200; n++) begin
         logic [AW-1:0] a;
         logic [3:0] be;
         bit wr, uses_rd, exp_ce;
         int r, k;
         a = AW'($urandom % 16);
         wr = ($urandom % 4) != 0;
         r = int'($urandom % 5);
         be = (r == 0) ? 4'hF : (r == 1) ? 4'h0 : 4'(1 + ($urandom % 14));
         dv = $urandom;
         if (!dirty[a] && ($urandom % 5) == 0) begin
            k = int'($urandom % 39);
            if (k < 32) inject(0, a, 32'(1) << k, 7'h0);
            else        inject(0, a, 32'h0, 7'(1) << (k - 32));
            dirty[a] = 1;
         end
         uses_rd = !wr || (be != 4'hF && be != 4'h0);
         exp_ce = uses_rd && dirty[a];
         do_op(0, wr, a, dv, be, rd, er, cyc, cec, bb);
         check("R5 no error in random", {63'd0, er}, 64'd0);
         check("R4 random pulse count", 64'(cec), {63'd0, exp_ce});
         check("R7 random busy", {63'd0, bb}, 64'd0);
         if (!wr) check("R6 random read", {32'd0, rd}, {32'd0, shadow[a]});
         else if (be != 4'h0) begin
            shadow[a] = ref_merge(shadow[a], dv, be);
            dirty[a] = 0;
         end
         if (!dirty[a]) begin
            check("R11 random stored data", {32'd0, mem0_i.dat[a]}, {32'd0, shadow[a]});
            check("R3 random stored check", {57'd0, mem0_i.chk[a]},
                  {57'd0, ref_code(shadow[a])});
         end
      end
      stall_en = 0;

      // R9: plain variant
      rc = rdc1;
      do_op(1, 1, 4'd2, 32'h1122_3344, 4'hF, rd, er, cyc, cec, bb);
      check("R9 plain full data", {32'd0, mem1_i.dat[2]}, {32'd0, 32'h1122_3344});
      check("R9 plain check zero", {57'd0, mem1_i.chk[2]}, 64'd0);
      do_op(1, 1, 4'd2, 32'hAABB_CCDD, 4'b0011, rd, er, cyc, cec, bb);
      check("R9 plain partial data", {32'd0, mem1_i.dat[2]}, {32'd0, 32'h1122_CCDD});
      check("R9 plain partial latency", 64'(cyc), 64'd2);
      check("R9 plain no fetch on writes", 64'(rdc1 - rc), 64'd0);
      inject(1, 4'd2, 32'h0000_0001, 7'h0);
      do_op(1, 0, 4'd2, 32'h0, 4'h0, rd, er, cyc, cec, bb);
      check("R9 plain raw read", {32'd0, rd}, {32'd0, 32'h1122_CCDC});
      check("R9 plain no pulse", 64'(cec), 64'd0);
      check("R9 plain no error", {63'd0, er}, 64'd0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL R7 watchdog: run hung actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule